// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing controller of a byte-wide serial EEPROM. It runs on a fast system clock and watches the two-wire bus lines after resynchronising them. It recognises bus start and stop events and decodes the device select word. It serves single-byte writes, page writes, random reads (a dummy write that sets the pointer, then a repeated start), reads from the current pointer, and sequential reads. It only ever pulls the data line low: `sda_oe` high means "drive SDA to zero", and the line is otherwise left to the pull-up.

Incoming write bytes go into a page buffer. They are copied into the array only when a stop closes a write sequence that carried at least one data byte. The copy runs inside a timed write cycle of `WR_CYC` system clocks. During that cycle the block answers nothing, so a host can poll the device word until it is acknowledged. A write-protect input keeps the array read-only without breaking the bus dialogue.

Top module: `tw_eeprom_slave`

## Requirements
- R1: While reset is high and after it falls, `sda_oe` is low, and the block takes no part in bus traffic until a START (SDA falling while SCL is high).
- R2: The device word is decoded as follows. Bits 7..4 must be 1010. Bit 3 is ignored. Bits 2..1 must equal `strap_i[1:0]`. Bit 0 selects read (1) or write (0). A match is acknowledged by holding SDA low for the ninth clock. A mismatch is not acknowledged, and the block then ignores the bus until the next START.
- R3: A write sequence is the device word, an upper address byte, a lower address byte and then data bytes, all MSB first and each acknowledged. The pointer is loaded with the low `ADDR_W` bits of {upper, lower}, and higher bits are ignored.
- R4: A STOP that follows at least one complete data byte, with `wp_i` low, starts a write cycle of exactly `WR_CYC` clocks that updates the array. During that cycle `sda_oe` stays low and the device word gets no acknowledge. After the cycle the device word is acknowledged again.
- R5: In a page write, consecutive bytes go to consecutive addresses. The low `PAGE_W` address bits wrap within the page, and a later byte for the same location replaces the earlier one.
- R6: A read-mode device word that follows a dummy write and a repeated START returns the byte at the loaded address.
- R7: When the host acknowledges a read byte (SDA low on the ninth clock), the block sends the byte at the next address. The address wraps from the top of the array to 0.
- R8: A read that follows no new address returns the byte after the last one accessed. After a read, the wrap is over the whole array. After a write, the wrap stays within that page.
- R9: After a host no-acknowledge the block releases SDA and sends no data on any further clocks until a STOP. A new START then works normally.
- R10: While `wp_i` is high, write sequences are still acknowledged, but the array is unchanged and no write cycle starts.
- R11: A STOP after a write sequence with no data bytes, or a STOP once two or more bits of a byte have been clocked, leaves memory unchanged and starts no write cycle.
- R12: `sda_oe` changes only while SCL is low. Read data goes out MSB first, each bit driven after a falling SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Board-level device select strap |
| wp_i | input | 1 | Write protect, high protects the whole array |
| sda_oe | output | 1 | Registered open-drain enable, high pulls SDA low |

## Verification
The checks on output timing assume the following about the host. It changes SDA only while SCL is low, except for START and STOP. Each SCL phase lasts well beyond the synchroniser delay. It never issues a START or STOP while the block is pulling SDA low. The write-protect checks also assume `wp_i` does not move during a transaction. The bench's bus tasks hold every SCL half period for eight system clocks, move SDA on the same edge that lowers SCL, and change `wp_i` only between transactions.

// File: rtl/twe_pkg.sv
package twe_pkg;
  // protocol phase of the slave engine
  typedef enum logic [3:0] {
    PH_IDLE,   // waiting for START
    PH_DEV,    // shifting device word
    PH_ADH,    // shifting upper address byte
    PH_ADL,    // shifting lower address byte
    PH_WDAT,   // shifting write data
    PH_ACK,    // ninth clock, block drives ACK
    PH_TX,     // shifting read data out
    PH_HACK,   // ninth clock, host answers
    PH_HOLD,   // released, waiting for STOP or START
    PH_WCYC    // timed write cycle
  } phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  // SYNC_N resync stages plus one history stage for edge detection
  logic [SYNC_N:0] scl_p;
  logic [SYNC_N:0] sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_N-1:0], scl_in};
      sda_p <= {sda_p[SYNC_N-1:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now   = scl_p[SYNC_N-1];
  assign scl_old   = scl_p[SYNC_N];
  assign sda_lvl   = sda_p[SYNC_N-1];
  assign sda_old   = sda_p[SYNC_N];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign bus_start = scl_now & scl_old & sda_old & ~sda_lvl;
  assign bus_stop  = scl_now & scl_old & ~sda_old & sda_lvl;
endmodule

// File: rtl/twe_ram.sv
module twe_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twe_engine.sv
module twe_engine
  import twe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7,
  parameter int WR_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_lvl,
  input  logic [1:0]        strap,
  input  logic              wp,
  input  logic [7:0]        arr_rdata,
  output logic [ADDR_W-1:0] arr_raddr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              pb_we,
  output logic [PAGE_W-1:0] pb_waddr,
  output logic [7:0]        pb_wdata,
  output logic [PAGE_W-1:0] pb_raddr,
  input  logic [7:0]        pb_rdata,
  output logic              sda_oe,
  output logic              busy
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int TW   = $clog2(WR_CYC + 1);
  localparam logic [TW-1:0]   WR_LAST = TW'(WR_CYC - 1);
  localparam logic [PAGE_W:0] PG_END  = {1'b1, {PAGE_W{1'b0}}};

  phase_e              st, nxt;
  logic [3:0]          cnt;
  logic [7:0]          sh;
  logic [7:0]          ahi;
  logic [ADDR_W-1:0]   ptr;
  logic [PAGE-1:0]     vld;
  logic                have;
  logic                oe;
  logic [TW-1:0]       tmr;
  logic [PAGE_W:0]     cidx;
  logic                c_go;
  logic [PAGE_W-1:0]   c_idx;
  logic                pb_we_q;
  logic [PAGE_W-1:0]   pb_wa_q;
  logic [7:0]          pb_wd_q;

  logic [7:0]  byte_in;
  logic [15:0] full_addr;
  logic        dev_ok;
  logic [2:0]  bsel;

  assign byte_in   = {sh[6:0], sda_lvl};
  assign full_addr = {ahi, byte_in};
  assign dev_ok    = (byte_in[7:4] == DEV_CODE) && (byte_in[2:1] == strap);
  assign bsel      = ~cnt[2:0];   // 7 - cnt for cnt in 0..7

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      nxt     <= PH_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ahi     <= '0;
      ptr     <= '0;
      vld     <= '0;
      have    <= 1'b0;
      oe      <= 1'b0;
      tmr     <= '0;
      cidx    <= '0;
      c_go    <= 1'b0;
      c_idx   <= '0;
      pb_we_q <= 1'b0;
      pb_wa_q <= '0;
      pb_wd_q <= '0;
    end else begin
      pb_we_q <= 1'b0;
      c_go    <= 1'b0;
      if (st == PH_WCYC) begin
        // bus is ignored; page buffer is copied one slot per clock
        oe <= 1'b0;
        if (cidx != PG_END) cidx <= cidx + (PAGE_W+1)'(1);
        c_go  <= (cidx != PG_END) && vld[cidx[PAGE_W-1:0]];
        c_idx <= cidx[PAGE_W-1:0];
        if (tmr == WR_LAST) begin
          st   <= PH_IDLE;
          tmr  <= '0;
          have <= 1'b0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end else if (bus_start) begin
        st   <= PH_DEV;
        cnt  <= '0;
        oe   <= 1'b0;
        have <= 1'b0;
      end else if (bus_stop) begin
        oe  <= 1'b0;
        cnt <= '0;
        // the stop's own SCL rise leaves cnt at 1 on a byte boundary
        if (st == PH_WDAT && cnt <= 4'd1 && have && !wp) begin
          st   <= PH_WCYC;
          tmr  <= '0;
          cidx <= '0;
        end else begin
          st   <= PH_IDLE;
          have <= 1'b0;
        end
      end else begin
        case (st)
          PH_DEV, PH_ADH, PH_ADL, PH_WDAT: begin
            if (scl_rise) begin
              sh  <= byte_in;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                cnt <= '0;
                st  <= PH_ACK;
                case (st)
                  PH_DEV: begin
                    if (!dev_ok) st <= PH_IDLE;
                    else nxt <= byte_in[0] ? PH_TX : PH_ADH;
                  end
                  PH_ADH: begin
                    ahi <= byte_in;
                    nxt <= PH_ADL;
                  end
                  PH_ADL: begin
                    ptr  <= ADDR_W'(full_addr);
                    vld  <= '0;
                    have <= 1'b0;
                    nxt  <= PH_WDAT;
                  end
                  default: begin
                    pb_we_q <= 1'b1;
                    pb_wa_q <= ptr[PAGE_W-1:0];
                    pb_wd_q <= byte_in;
                    vld[ptr[PAGE_W-1:0]] <= 1'b1;
                    have <= 1'b1;
                    ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                    nxt <= PH_WDAT;
                  end
                endcase
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (!oe) begin
                oe <= 1'b1;
              end else if (nxt == PH_TX) begin
                oe  <= ~arr_rdata[7];
                cnt <= '0;
                st  <= PH_TX;
              end else begin
                oe <= 1'b0;
                st <= nxt;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe <= 1'b0;
                st <= PH_HACK;
              end else begin
                oe <= ~arr_rdata[bsel];
              end
            end
          end
          PH_HACK: begin
            if (scl_rise) begin
              ptr <= ptr + ADDR_W'(1);
              cnt <= '0;
              st  <= sda_lvl ? PH_HOLD : PH_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign arr_raddr = ptr;
  assign arr_we    = c_go;
  assign arr_waddr = {ptr[ADDR_W-1:PAGE_W], c_idx};
  assign arr_wdata = pb_rdata;
  assign pb_we     = pb_we_q;
  assign pb_waddr  = pb_wa_q;
  assign pb_wdata  = pb_wd_q;
  assign pb_raddr  = cidx[PAGE_W-1:0];
  assign sda_oe    = oe;
  assign busy      = (st == PH_WCYC);
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7,
  parameter int WR_CYC = 500000,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_busy;

  logic [ADDR_W-1:0] arr_raddr, arr_waddr;
  logic [7:0]        arr_rdata, arr_wdata;
  logic              arr_we;
  logic              pb_we;
  logic [PAGE_W-1:0] pb_waddr, pb_raddr;
  logic [7:0]        pb_wdata, pb_rdata;

  twe_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_i),
    .sda_in    (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  twe_engine #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .WR_CYC (WR_CYC)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_lvl   (sda_lvl),
    .strap     (strap_i),
    .wp        (wp_i),
    .arr_rdata (arr_rdata),
    .arr_raddr (arr_raddr),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata),
    .pb_we     (pb_we),
    .pb_waddr  (pb_waddr),
    .pb_wdata  (pb_wdata),
    .pb_raddr  (pb_raddr),
    .pb_rdata  (pb_rdata),
    .sda_oe    (sda_oe),
    .busy      (wr_busy)
  );

  twe_ram #(.AW(ADDR_W), .DW(8)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (arr_raddr),
    .rdata (arr_rdata)
  );

  twe_ram #(.AW(PAGE_W), .DW(8)) u_pagebuf (
    .clk   (clk),
    .we    (pb_we),
    .waddr (pb_waddr),
    .wdata (pb_wdata),
    .raddr (pb_raddr),
    .rdata (pb_rdata)
  );
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk #(
  parameter int WR_CYC = 500000
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe,
  input logic busy
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) bcnt <= '0;
    else     bcnt <= busy ? bcnt + 32'd1 : 32'd0;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe);

  // R4
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R4
  wr_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == 32'(WR_CYC)));

  // R10
  wp_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wp_i);

  // R12
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk #(.WR_CYC(WR_CYC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_i  (scl_i),
  .wp_i   (wp_i),
  .sda_oe (sda_oe),
  .busy   (wr_busy)
);

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;
  localparam int AW = 8;
  localparam int PW = 3;
  localparam int WC = 300;
  localparam int H  = 8;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic hlow = 1'b0;
  logic wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  logic sda;

  always #10 clk = ~clk;   // 50 MHz

  assign sda = ~(sda_oe | hlow);

  tw_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYC(WC)) uut (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (sda),
    .strap_i (strap),
    .wp_i    (wp),
    .sda_oe  (sda_oe)
  );

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;
  bit fin  = 1'b0;
  logic [7:0] exp_mem [NB];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    hlow = 1'b0; tk(H);
    scl = 1'b1;  tk(H);
    hlow = 1'b1; tk(H);
    scl = 1'b0;  tk(H);
  endtask

  task automatic b_stop();
    hlow = 1'b1; tk(H);
    scl = 1'b1;  tk(H);
    hlow = 1'b0; tk(H);
  endtask

  task automatic send_bit(bit b);
    hlow = !b; tk(H);
    scl = 1'b1; tk(H);
    scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    hlow = 1'b0; tk(H);
    ack = (sda == 1'b0);
    scl = 1'b1; tk(H);
    scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit hack);
    for (int i = 7; i >= 0; i--) begin
      hlow = 1'b0; tk(H);
      d[i] = sda;
      scl = 1'b1; tk(H);
      scl = 1'b0;
    end
    hlow = hack; tk(H);
    scl = 1'b1; tk(H);
    scl = 1'b0;
  endtask

  function automatic logic [7:0] devw();
    return {4'b1010, 1'b0, strap, 1'b0};
  endfunction

  function automatic logic [7:0] devr();
    return {4'b1010, 1'b0, strap, 1'b1};
  endfunction

  task automatic set_addr(int a, output bit ok);
    bit a1, a2, a3;
    b_start();
    send_byte(devw(), a1);
    send_byte(8'hA5 ^ 8'(a), a2);   // upper byte: beyond ADDR_W, ignored
    send_byte(8'(a), a3);
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_seq(int a, int n, string tag);
    bit ok, ak;
    logic [7:0] d;
    set_addr(a, ok);
    b_start();
    send_byte(devr(), ak);
    chk(ok & ak, tag, {ok, ak}, 3);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d === exp_mem[8'(a + i)], tag, d, exp_mem[8'(a + i)]);
    end
    b_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    bit ak;
    b_start();
    send_byte(devr(), ak);
    recv_byte(d, 1'b0);
    b_stop();
  endtask

  task automatic dev_probe(output bit ak);
    b_start();
    send_byte(devw(), ak);
    b_stop();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !fin) begin
      fin = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit ok, ak, allok, seen;
    logic [7:0] d;

    tk(10);
    rst = 1'b0;
    tk(4);
    // R1: released after reset
    chk(sda_oe == 1'b0 && sda == 1'b1, "R1 reset", sda_oe, 0);

    // R2: sweep of select bits, bit 3 don't care
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 2; x++) begin
        b_start();
        send_byte({4'b1010, 1'(x), 2'(s), 1'b0}, ak);
        b_stop();
        chk(ak == (2'(s) == strap), "R2 select", ak, 2'(s) == strap);
      end
    end
    b_start();
    send_byte({4'b1011, 1'b0, strap, 1'b0}, ak);
    b_stop();
    chk(!ak, "R2 code", ak, 0);

    // R3 R4: fill the whole array page by page
    for (int p = 0; p < NB / (1 << PW); p++) begin
      set_addr(p << PW, allok);
      for (int k = 0; k < (1 << PW); k++) begin
        send_byte(pat((p << PW) + k), ak);
        allok &= ak;
        exp_mem[(p << PW) + k] = pat((p << PW) + k);
      end
      b_stop();
      chk(allok, "R3 write acks", allok, 1);
      if (p == 0) begin
        dev_probe(ak);
        chk(!ak, "R4 busy no ack", ak, 0);
      end
      tk(WC + 40);
      if (p == 0) begin
        dev_probe(ak);
        chk(ak, "R4 ack after cycle", ak, 1);
      end
    end

    // R6 R7 R12: random read at 0, sequential through wrap
    rd_seq(0, NB + 1, "R6 R7 R12 seq read");

    // R8: current address after read (last read address 0)
    cur_read(d);
    chk(d === exp_mem[1], "R8 current after read", d, exp_mem[1]);

    // R5: page wrap and overwrite, 10 bytes from 86 in page 80..87
    set_addr(86, allok);
    for (int k = 0; k < 10; k++) begin
      send_byte(8'hC0 + 8'(k), ak);
      allok &= ak;
      exp_mem[80 + ((6 + k) % 8)] = 8'hC0 + 8'(k);
    end
    b_stop();
    chk(allok, "R5 acks", allok, 1);
    tk(WC + 40);
    rd_seq(80, 8, "R5 page wrap");

    // R8: current address after write wraps inside page 56..63
    set_addr(63, ok);
    send_byte(8'h3C, ak);
    b_stop();
    exp_mem[63] = 8'h3C;
    tk(WC + 40);
    cur_read(d);
    chk(d === exp_mem[56], "R8 current after write", d, exp_mem[56]);

    // R10: write protect
    wp = 1'b1;
    set_addr(100, ok);
    send_byte(8'h5A, ak);
    b_stop();
    chk(ok & ak, "R10 acks under wp", {ok, ak}, 3);
    dev_probe(ak);
    chk(ak, "R10 no write cycle", ak, 1);
    wp = 1'b0;
    rd_seq(100, 1, "R10 array kept");

    // R11: stop with no data, then stop mid-byte after one full byte
    set_addr(120, ok);
    b_stop();
    dev_probe(ak);
    chk(ak, "R11 no-data stop", ak, 1);
    set_addr(121, ok);
    send_byte(8'h77, ak);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    b_stop();
    dev_probe(ak);
    chk(ak, "R11 mid-byte stop", ak, 1);
    rd_seq(120, 2, "R11 memory kept");

    // R9: NACK then bus released, no data until STOP
    set_addr(10, ok);
    b_start();
    send_byte(devr(), ak);
    recv_byte(d, 1'b0);
    chk(d === exp_mem[10], "R9 byte", d, exp_mem[10]);
    seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      hlow = 1'b0; tk(H);
      if (sda == 1'b0) seen = 1'b1;
      scl = 1'b1; tk(H);
      scl = 1'b0;
    end
    chk(!seen, "R9 released", seen, 0);
    b_stop();
    cur_read(d);
    chk(d === exp_mem[11], "R9 R8 after nack", d, exp_mem[11]);

    if (!fin) begin
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule